// File: doc/BRIEF.md
# Test-and-Set Lock Engine

This block is a dedicated target on the on-chip interconnect. It holds a bank of one-bit lock words, one per aligned word address. Reading a lock is an atomic acquire attempt. The read returns the lock's prior value and leaves the lock at 1 in the same operation. A thread that gets 0 back now holds the lock. A thread that gets 1 back did not get it and retries later.

Writing a lock sets its value directly: zero data releases it and any nonzero data forces it to 1. The engine keeps no record of which initiator holds a lock. Keeping releases to the holder is left to software. Every request gets exactly one response, writes included, so an initiator can wait until a release has completed before it switches to another target.

Each request is served in a single cycle and answered on the next cycle. An address whose word index lies beyond the lock bank gets an error response and changes no lock.

Top module: `sema_engine`

## Requirements
- R1: A read response carries the lock's prior value in bit 0 of `rsp_rdata`, and bits above bit 0 are zero.
- R2: After a read of a valid lock, that lock holds 1 whatever it held before, so the next read of it returns 1.
- R3: Two reads of the same free lock in consecutive cycles return 0 and then 1.
- R4: A write whose data is all zeros clears the addressed lock, so a following read returns 0.
- R5: A write whose data has any bit set sets the addressed lock to 1.
- R6: Every request in cycle n gets a response with `rsp_valid` high in cycle n+1. `rsp_valid` is low in any cycle that follows a cycle with no request.
- R7: A write response to a valid lock has `rsp_err` low and `rsp_rdata` equal to zero. A read response to a valid lock also has `rsp_err` low.
- R8: The lock index is `req_addr[ADDR_W-1:2]`. The two low address bits are ignored.
- R9: When the lock index is at least `NUM_LOCKS`, the response has `rsp_err` high and `rsp_rdata` zero, and no lock changes.
- R10: Reset clears every lock to 0, and no response is issued while reset is held.
- R11: A request changes only the lock it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read (acquire attempt) |
| req_addr | input | ADDR_W | Byte offset within the engine |
| req_wdata | input | DATA_W | Write data; zero releases, nonzero sets |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Offset fell outside the lock bank |
| rsp_rdata | output | DATA_W | Prior lock value in bit 0 for reads, zero otherwise |

## Verification
The bench builds the engine with 32 locks and an 8-bit offset. That gives 64 word indices, so half the address space lies beyond the lock bank. Error responses, and the check that they leave the aliased lower locks untouched, can therefore be reached with ordinary addresses. A behavioural lock model predicts every response cycle by cycle. Directed runs of back-to-back reads, releases, nonzero writes and unaligned offsets are followed by a long random stream with idle gaps.

// File: rtl/sema_pkg.sv
package sema_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_ACQ  = 2'd1,
      OP_SET  = 2'd2,
      OP_CLR  = 2'd3
   } lock_op_e;
endpackage

// File: rtl/sema_decode.sv
module sema_decode
   import sema_pkg::*;
#(
   parameter int NUM_LOCKS = 32,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   localparam int IDX_W    = $clog2(NUM_LOCKS)
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [IDX_W-1:0]  lock_idx,
   output logic              out_of_range,
   output lock_op_e          lock_op
);
   localparam int WIDX_W = ADDR_W - 2;

   logic [WIDX_W-1:0] word_idx;
   logic              in_range;

   assign word_idx = req_addr[ADDR_W-1:2];
   assign lock_idx = word_idx[IDX_W-1:0];

   generate
      if (NUM_LOCKS == (1 << WIDX_W)) begin : g_full_map
         assign in_range = 1'b1;
      end else begin : g_partial_map
         localparam logic [WIDX_W-1:0] LIMIT = WIDX_W'(NUM_LOCKS);
         assign in_range = (word_idx < LIMIT);
      end
   endgenerate

   assign out_of_range = !in_range;

   always_comb begin
      lock_op = OP_NONE;
      if (req_valid && in_range) begin
         if (!req_write)           lock_op = OP_ACQ;
         else if (|req_wdata)      lock_op = OP_SET;
         else                      lock_op = OP_CLR;
      end
   end
endmodule

// File: rtl/sema_lock_bank.sv
module sema_lock_bank
   import sema_pkg::*;
#(
   parameter int NUM_LOCKS = 32,
   localparam int IDX_W    = $clog2(NUM_LOCKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDX_W-1:0]     lock_idx,
   input  lock_op_e             lock_op,
   output logic                 prior_bit,
   output logic [NUM_LOCKS-1:0] lock_q
);
   localparam logic [NUM_LOCKS-1:0] ONE_HOT0 = NUM_LOCKS'(1);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LOCKS; gi++) begin : g_cell
         logic hit;
         assign hit = (lock_op != OP_NONE) && (lock_idx == IDX_W'(gi));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lock_q[gi] <= 1'b0;
            end else if (hit) begin
               lock_q[gi] <= (lock_op != OP_CLR);
            end
         end
      end
   endgenerate

   assign prior_bit = lock_q[lock_idx];

   // R2
   acquire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_op == OP_ACQ) |=> lock_q[$past(lock_idx)]);

   // R4
   release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_op == OP_CLR) |=> !lock_q[$past(lock_idx)]);

   // R11
   others_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_op != OP_NONE) |=>
         (((lock_q ^ $past(lock_q)) & ~(ONE_HOT0 << $past(lock_idx))) == '0));
endmodule

// File: rtl/sema_rsp.sv
module sema_rsp #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              out_of_range,
   input  logic              prior_bit,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && out_of_range;
         rsp_rdata <= (req_valid && !req_write && !out_of_range)
                      ? {{(DATA_W-1){1'b0}}, prior_bit} : '0;
      end
   end

   // R6
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R6
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R7
   write_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_rdata == '0));
endmodule

// File: rtl/sema_engine.sv
module sema_engine
   import sema_pkg::*;
#(
   parameter int NUM_LOCKS = 32,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata
);
   localparam int IDX_W = $clog2(NUM_LOCKS);

   generate
      if (NUM_LOCKS < 2) begin : g_bad_count
         $error("sema_engine: NUM_LOCKS must be at least 2");
      end
      if (ADDR_W < 3 || (1 << (ADDR_W - 2)) < NUM_LOCKS) begin : g_bad_addr
         $error("sema_engine: ADDR_W too narrow for NUM_LOCKS words");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("sema_engine: DATA_W must be positive");
      end
   endgenerate

   logic [IDX_W-1:0]     lock_idx;
   logic                 out_of_range;
   lock_op_e             lock_op;
   logic                 prior_bit;
   logic [NUM_LOCKS-1:0] lock_q;

   sema_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .lock_idx    (lock_idx),
      .out_of_range(out_of_range),
      .lock_op     (lock_op)
   );

   sema_lock_bank #(.NUM_LOCKS(NUM_LOCKS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_idx (lock_idx),
      .lock_op  (lock_op),
      .prior_bit(prior_bit),
      .lock_q   (lock_q)
   );

   sema_rsp #(.DATA_W(DATA_W)) u_rsp (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .out_of_range(out_of_range),
      .prior_bit   (prior_bit),
      .rsp_valid   (rsp_valid),
      .rsp_err     (rsp_err),
      .rsp_rdata   (rsp_rdata)
   );

   // R9
   bad_addr_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && out_of_range) |=> ($stable(lock_q) && rsp_err));

   // R1
   read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_rdata[DATA_W-1:1] == '0));
endmodule

// File: tb/sema_engine_test.sv
module sema_engine_test;
   localparam int NL = 32;
   localparam int AW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic          rsp_err;
   logic [DW-1:0] rsp_rdata;

   always #10 clk = ~clk;

   sema_engine #(.NUM_LOCKS(NL), .ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
   );

   int    n_checks = 0;
   int    n_fail = 0;
   bit    model [NL];
   bit    exp_v = 0;
   bit    exp_e = 0;
   int    exp_d = 0;
   string exp_tag = "R6";
   bit    finished = 0;

   task automatic check_rsp();
      n_checks++;
      if (rsp_valid !== exp_v ||
          (exp_v && (rsp_err !== exp_e || rsp_rdata !== DW'(exp_d)))) begin
         n_fail++;
         $display("FAIL %s: got v=%0b e=%0b d=%0h, expected v=%0b e=%0b d=%0h",
                  exp_tag, rsp_valid, rsp_err, rsp_rdata, exp_v, exp_e, exp_d);
      end
   endtask

   // One cycle: check the response to the previous request, then drive the next
   task automatic step(input bit v, input bit w, input int a, input int d, input string tag);
      int idx;
      @(negedge clk);
      check_rsp();
      req_valid = v; req_write = w; req_addr = AW'(a); req_wdata = DW'(d);
      exp_v = v; exp_e = 0; exp_d = 0; exp_tag = tag;
      if (v) begin
         idx = (a >> 2) & ((1 << (AW - 2)) - 1);
         if (idx >= NL) exp_e = 1;
         else if (!w) begin exp_d = model[idx]; model[idx] = 1; end
         else model[idx] = (d != 0);
      end
   endtask

   task automatic rd(input int idx, input string tag);
      step(1, 0, idx * 4, 0, tag);
   endtask

   task automatic wr(input int idx, input int d, input string tag);
      step(1, 1, idx * 4, d, tag);
   endtask

   initial begin
      for (int i = 0; i < NL; i++) model[i] = 0;
      repeat (3) begin
         @(negedge clk);
         n_checks++;
         if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: rsp_valid=%0b in reset, expected 0", rsp_valid);
         end
      end
      rst_n = 1'b1;
      // R10 all clear after reset, R1 old value in bit 0
      for (int i = 0; i < NL; i++) rd(i, "R10");
      // R2 second read sees 1
      for (int i = 0; i < NL; i++) rd(i, "R2");
      // R3 back-to-back reads of a free lock
      wr(5, 0, "R4");
      rd(5, "R3");
      rd(5, "R3");
      // R4 / R5 writes
      wr(3, 0, "R7");
      rd(3, "R4");
      wr(3, 7, "R5");
      step(0, 0, 0, 0, "R6");
      wr(3, 0, "R4");
      rd(3, "R4");
      wr(4, 0, "R4");
      wr(4, 32'h8000_0000, "R5");
      rd(4, "R5");
      // R8 low address bits ignored
      wr(9, 0, "R8");
      step(1, 0, 9 * 4 + 3, 0, "R8");
      step(1, 0, 9 * 4 + 1, 0, "R8");
      // R9 out-of-range: no change to the aliased lower lock
      wr(2, 0, "R9");
      rd(34, "R9");
      wr(34, 1, "R9");
      step(1, 1, 63 * 4 + 2, 0, "R9");
      rd(2, "R9");
      // R11 random stream with idle gaps
      for (int k = 0; k < 3000; k++) begin
         int sel = $urandom_range(0, 9);
         int a   = $urandom_range(0, 255);
         int d   = ($urandom_range(0, 1) == 1) ? int'($urandom) : 0;
         if (sel < 2) step(0, 0, 0, 0, "R6");
         else step(1, sel >= 6, a, d, "R11");
      end
      step(0, 0, 0, 0, "R6");
      step(0, 0, 0, 0, "R6");
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule